// File: doc/BRIEF.md
# Serial Port FIFO Flag and Request Unit

This unit sits beside the transmit and receive FIFOs of a synchronous serial port. It turns their fill levels into status flags: transmit empty, transmit request, receive request, receive full and control-word ready. It also turns them into three interrupt lines. A transfer request follows a programmable watermark. The transmit side compares the free space against its watermark. The receive side compares the number of stored words against its own. Each request drops again without help once the level falls back.

The unit also holds a single received control word. A strobe from the receiver loads a new word, and a later word replaces it even if the first was never read. Reading the word clears its ready flag. The full flag clears when the receive data register is read. When a direction is disabled, its flags are forced to zero. Every flag is registered, so it follows its inputs by one clock. Each interrupt line is registered again, one clock after the flags.

Top module: `sio_flag_unit`

## Requirements
- R1: status[0] (transmit empty) is 1 one clock after txCount equals 0 and 0 one clock after any other count.
- R2: status[1] (transmit request) sets one clock after DEPTH-txCount exceeds txMark. It clears one clock after that free space is below txMark. When the free space equals txMark it keeps its value.
- R3: status[2] (receive request) sets one clock after rxCount exceeds rxMark and clears one clock after rxCount is below rxMark. When they are equal it keeps its value.
- R4: While txEnable is 0, status[1] is 0 on the next clock. While rxEnable is 0, status[2], status[3] and status[4] are 0 on the next clock, and a ctrlWrite has no effect.
- R5: status[3] (receive full) sets one clock after rxCount equals DEPTH with rxEnable 1. After that it clears only on a rxDataRead pulse. If rxDataRead and the full level occur in the same cycle, the flag stays set.
- R6: status[4] (control ready) sets on a ctrlWrite pulse, and on the same clock ctrlData takes ctrlWord. A ctrlWrite while the flag is already set overwrites ctrlData. A ctrlRead pulse clears the flag. A ctrlRead and a ctrlWrite in the same cycle leave the flag set, holding the new word.
- R7: One clock after the flags, txIrq = status[1]&intEnable[0] and rxIrq = status[2]&intEnable[1]. ctrlIrq = (status[3]&intEnable[2]) | (status[4]&intEnable[3]).
- R8: While rstN is 0, status, ctrlData and all three interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txCount | input | CNT_W | Words held in the transmit FIFO |
| rxCount | input | CNT_W | Words held in the receive FIFO |
| txMark | input | CNT_W | Transmit watermark on free space |
| rxMark | input | CNT_W | Receive watermark on occupancy |
| txEnable | input | 1 | Transmitter enable |
| rxEnable | input | 1 | Receiver enable |
| intEnable | input | 4 | Interrupt enables: 0 tx request, 1 rx request, 2 rx full, 3 control ready |
| rxDataRead | input | 1 | Receive data register read pulse |
| ctrlRead | input | 1 | Control word read pulse |
| ctrlWrite | input | 1 | New control word pulse |
| ctrlWord | input | CTRL_W | Incoming control word |
| status | output | 5 | Flags: 0 tx empty, 1 tx request, 2 rx request, 3 rx full, 4 control ready |
| ctrlData | output | CTRL_W | Stored control word |
| txIrq | output | 1 | Transmit interrupt |
| rxIrq | output | 1 | Receive interrupt |
| ctrlIrq | output | 1 | Control interrupt |

## Verification
A clear-on-read and a set event can land in the same cycle. One case is a rxDataRead while rxCount sits at DEPTH. The other is a ctrlRead together with a ctrlWrite carrying a fresh word. The bench drives each pair inside one clock and expects the flag to stay 1 on the next clock. In the control case it also expects ctrlData to show the fresh word. The full watermark sweep starts from both preset flag values, so the hold-at-equality case is judged against the state the flag had before.

// File: rtl/sio_flag_pkg.sv
package sio_flag_pkg;

  localparam int NUM_SR = 4;
  localparam int SR_TXREQ = 0;
  localparam int SR_RXREQ = 1;
  localparam int SR_RXFULL = 2;
  localparam int SR_CTRLRDY = 3;

  typedef struct packed {
    logic              txEmptyNext;
    logic [NUM_SR-1:0] setVec;
    logic [NUM_SR-1:0] clrVec;
    logic              loadCtrl;
  } flagStrobes_t;

endpackage

// File: rtl/sio_flag_ctrl.sv
module sio_flag_ctrl
  import sio_flag_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] txMark,
  input  logic [CNT_W-1:0] rxMark,
  input  logic             txEnable,
  input  logic             rxEnable,
  input  logic             rxDataRead,
  input  logic             ctrlRead,
  input  logic             ctrlWrite,
  output flagStrobes_t     strobes
);

  localparam logic [CNT_W-1:0] FULL_LEVEL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] txFree;

  assign txFree = FULL_LEVEL - txCount;

  always_comb begin
    strobes = '0;
    strobes.txEmptyNext = (txCount == '0);
    // transmit request: free space against watermark
    strobes.setVec[SR_TXREQ] = txEnable && (txFree > txMark);
    strobes.clrVec[SR_TXREQ] = !txEnable || (txFree < txMark);
    // receive request: occupancy against watermark
    strobes.setVec[SR_RXREQ] = rxEnable && (rxCount > rxMark);
    strobes.clrVec[SR_RXREQ] = !rxEnable || (rxCount < rxMark);
    // receive full: level sets, read clears
    strobes.setVec[SR_RXFULL] = rxEnable && (rxCount == FULL_LEVEL);
    strobes.clrVec[SR_RXFULL] = !rxEnable || rxDataRead;
    // control word ready: write sets, read clears
    strobes.setVec[SR_CTRLRDY] = rxEnable && ctrlWrite;
    strobes.clrVec[SR_CTRLRDY] = !rxEnable || ctrlRead;
    strobes.loadCtrl = rxEnable && ctrlWrite;
  end

endmodule

// File: rtl/sio_flag_dp.sv
module sio_flag_dp
  import sio_flag_pkg::*;
#(
  parameter int CTRL_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  flagStrobes_t       strobes,
  input  logic [CTRL_W-1:0]  ctrlWord,
  input  logic [3:0]         intEnable,
  output logic [4:0]         status,
  output logic [CTRL_W-1:0]  ctrlData,
  output logic               txIrq,
  output logic               rxIrq,
  output logic               ctrlIrq
);

  logic              txEmptyQ;
  logic [NUM_SR-1:0] srQ;

  always_ff @(posedge clk) begin
    if (!rstN) txEmptyQ <= 1'b0;
    else       txEmptyQ <= strobes.txEmptyNext;
  end

  // set/clear flags, set has priority
  for (genvar i = 0; i < NUM_SR; i++) begin : g_sr
    always_ff @(posedge clk) begin
      if (!rstN)                  srQ[i] <= 1'b0;
      else if (strobes.setVec[i]) srQ[i] <= 1'b1;
      else if (strobes.clrVec[i]) srQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 ctrlData <= '0;
    else if (strobes.loadCtrl) ctrlData <= ctrlWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txIrq   <= 1'b0;
      rxIrq   <= 1'b0;
      ctrlIrq <= 1'b0;
    end else begin
      txIrq   <= srQ[SR_TXREQ] & intEnable[0];
      rxIrq   <= srQ[SR_RXREQ] & intEnable[1];
      ctrlIrq <= (srQ[SR_RXFULL] & intEnable[2]) | (srQ[SR_CTRLRDY] & intEnable[3]);
    end
  end

  assign status = {srQ[SR_CTRLRDY], srQ[SR_RXFULL], srQ[SR_RXREQ], srQ[SR_TXREQ], txEmptyQ};

  // R7: interrupt lines follow the registered flags by one clock
  assert_tx_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> txIrq == ($past(srQ[SR_TXREQ]) & $past(intEnable[0])));
  // R6: a load strobe leaves the ready flag set
  assert_load_sets_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCtrl |=> srQ[SR_CTRLRDY]);

endmodule

// File: rtl/sio_flag_unit.sv
module sio_flag_unit
  import sio_flag_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CTRL_W = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [CNT_W-1:0]  txMark,
  input  logic [CNT_W-1:0]  rxMark,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic [3:0]        intEnable,
  input  logic              rxDataRead,
  input  logic              ctrlRead,
  input  logic              ctrlWrite,
  input  logic [CTRL_W-1:0] ctrlWord,
  output logic [4:0]        status,
  output logic [CTRL_W-1:0] ctrlData,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              ctrlIrq
);

  flagStrobes_t strobes;

  sio_flag_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .txCount(txCount), .rxCount(rxCount), .txMark(txMark), .rxMark(rxMark),
    .txEnable(txEnable), .rxEnable(rxEnable), .rxDataRead(rxDataRead),
    .ctrlRead(ctrlRead), .ctrlWrite(ctrlWrite), .strobes(strobes)
  );

  sio_flag_dp #(.CTRL_W(CTRL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ctrlWord(ctrlWord),
    .intEnable(intEnable), .status(status), .ctrlData(ctrlData),
    .txIrq(txIrq), .rxIrq(rxIrq), .ctrlIrq(ctrlIrq)
  );

  // R4: disabled transmitter forces its request low
  assert_tx_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> !status[1]);
  // R5: full level with receiver on keeps full set, even against a read
  assert_full_priority_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && rxCount == CNT_W'(DEPTH)) |=> status[3]);
  // R3: equality holds the receive request
  assert_rx_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && rxCount == rxMark) |=> status[2] == $past(status[2]));
  // R6: control word captured on write
  assert_ctrl_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && ctrlWrite) |=> ctrlData == $past(ctrlWord));
  // R1: empty flag tracks the transmit level
  assert_tx_empty_R1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> status[0] == ($past(txCount) == '0));

endmodule

// File: tb/sio_flag_unit_test.sv
module sio_flag_unit_test;

  localparam int DEPTH = 8;
  localparam int CTRL_W = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] txCount = '0, rxCount = '0, txMark = '0, rxMark = '0;
  logic txEnable = 1'b0, rxEnable = 1'b0;
  logic [3:0] intEnable = '0;
  logic rxDataRead = 1'b0, ctrlRead = 1'b0, ctrlWrite = 1'b0;
  logic [CTRL_W-1:0] ctrlWord = '0;
  logic [4:0] status;
  logic [CTRL_W-1:0] ctrlData;
  logic txIrq, rxIrq, ctrlIrq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  sio_flag_unit #(.DEPTH(DEPTH), .CTRL_W(CTRL_W)) uut (
    .clk(clk), .rstN(rstN), .txCount(txCount), .rxCount(rxCount),
    .txMark(txMark), .rxMark(rxMark), .txEnable(txEnable), .rxEnable(rxEnable),
    .intEnable(intEnable), .rxDataRead(rxDataRead), .ctrlRead(ctrlRead),
    .ctrlWrite(ctrlWrite), .ctrlWord(ctrlWord), .status(status),
    .ctrlData(ctrlData), .txIrq(txIrq), .rxIrq(rxIrq), .ctrlIrq(ctrlIrq)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    // R8 reset state
    check("R8 status", int'(status), 0);
    check("R8 ctrlData", int'(ctrlData), 0);
    check("R8 irqs", int'({txIrq, rxIrq, ctrlIrq}), 0);
    rstN = 1'b1;

    // R1 R2 R7 transmit sweep
    for (int p = 0; p < 2; p++)
      for (int c = 0; c <= DEPTH; c++)
        for (int m = 0; m <= DEPTH; m++) begin
          int free, expReq;
          txCount = '0; txMark = '0; txEnable = (p == 1);
          step();
          txCount = CNT_W'(c); txMark = CNT_W'(m); txEnable = 1'b1;
          intEnable = 4'((c + m) & 1);
          step();
          free = DEPTH - c;
          expReq = (free > m) ? 1 : (free < m) ? 0 : p;
          check("R2 txReq", int'(status[1]), expReq);
          check("R1 txEmpty", int'(status[0]), (c == 0) ? 1 : 0);
          step();
          check("R7 txIrq", int'(txIrq), expReq & ((c + m) & 1));
        end

    // R4 transmit gating
    txCount = '0; txMark = '0; txEnable = 1'b0;
    step();
    check("R4 txReq off", int'(status[1]), 0);

    // R3 R5 R7 receive sweep
    for (int p = 0; p < 2; p++)
      for (int c = 0; c <= DEPTH; c++)
        for (int m = 0; m <= DEPTH; m++) begin
          int expReq, expFull;
          rxCount = CNT_W'(DEPTH); rxMark = '0; rxEnable = (p == 1);
          step();
          rxCount = CNT_W'(c); rxMark = CNT_W'(m); rxEnable = 1'b1;
          intEnable = 4'(((c & 1) << 1) | ((m & 1) << 2));
          step();
          expReq = (c > m) ? 1 : (c < m) ? 0 : p;
          expFull = (p == 1 || c == DEPTH) ? 1 : 0;
          check("R3 rxReq", int'(status[2]), expReq);
          check("R5 rxFull", int'(status[3]), expFull);
          step();
          check("R7 rxIrq", int'(rxIrq), expReq & (c & 1));
          check("R7 ctrlIrq", int'(ctrlIrq), expFull & (m & 1));
        end

    // R5 read clears full, read at full level keeps it
    rxCount = CNT_W'(DEPTH); rxMark = CNT_W'(DEPTH); rxEnable = 1'b1;
    step();
    rxCount = CNT_W'(DEPTH - 1);
    step();
    check("R5 full held", int'(status[3]), 1);
    rxDataRead = 1'b1; rxCount = CNT_W'(DEPTH);
    step();
    check("R5 set wins read", int'(status[3]), 1);
    rxCount = CNT_W'(DEPTH - 1);
    step();
    rxDataRead = 1'b0;
    check("R5 read clears", int'(status[3]), 0);

    // R6 control word path
    intEnable = 4'b1000;
    ctrlWrite = 1'b1; ctrlWord = 8'h5A;
    step();
    ctrlWrite = 1'b0;
    check("R6 ready", int'(status[4]), 1);
    check("R6 data", int'(ctrlData), 'h5A);
    step();
    check("R7 ctrlIrq ready", int'(ctrlIrq), 1);
    ctrlWrite = 1'b1; ctrlWord = 8'hC3;
    step();
    ctrlWrite = 1'b0;
    check("R6 overwrite", int'(ctrlData), 'hC3);
    ctrlRead = 1'b1; ctrlWrite = 1'b1; ctrlWord = 8'h17;
    step();
    ctrlWrite = 1'b0;
    check("R6 write wins read", int'(status[4]), 1);
    check("R6 write wins data", int'(ctrlData), 'h17);
    step();
    ctrlRead = 1'b0;
    check("R6 read clears", int'(status[4]), 0);

    // R4 receive gating
    rxCount = CNT_W'(DEPTH); rxMark = '0;
    ctrlWrite = 1'b1; ctrlWord = 8'h99;
    step();
    ctrlWrite = 1'b0;
    rxEnable = 1'b0;
    step();
    check("R4 rx flags off", int'(status[4:2]), 0);
    ctrlWrite = 1'b1; ctrlWord = 8'h33;
    step();
    ctrlWrite = 1'b0;
    check("R4 write ignored ready", int'(status[4]), 0);
    check("R4 write ignored data", int'(ctrlData), 'h99);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule